// File: doc/BRIEF.md
# Addressed Serial Control Word Receiver

This block takes control frames from a host over three wires: a select line, a serial clock and a serial data line. All three are slow compared with the system clock. They are brought into the system clock domain and sampled there. Each serial-clock rising edge shifts in one data bit. Bits clocked while select is low form a device address, and only the last eight of them are kept. When select rises, that address is compared with the device address.

With select high, payload bits are shifted into a 44-bit register. Only when the address matched does this happen. Only the most recent 44 bits survive, so a host that pads its frame to a whole number of bytes still lands bit D0 at word bit 0. When select falls, a frame that matched and delivered at least 44 payload bits is committed. The block then presents the word on a registered output with a one-cycle valid strobe. Three positions in the word are reserved test bits. Any of them set raises a sticky error flag, but the word is still delivered.

Top module: `ctl_frame_rx`

## Requirements
- R1: While reset is high and after its release, `word_o` is zero, `word_vld_o` is low and `tbit_err_o` is low.
- R2: Address bits are sent least significant first. A frame whose address equals 0x81 and which carries 44 payload bits produces a strobe. After it, `word_o` bit 0 holds the first payload bit sent and bit 43 holds the last.
- R3: A frame whose address differs from 0x81 produces no strobe and leaves `word_o` unchanged.
- R4: When more than eight bits are clocked while select is low, only the last eight form the address.
- R5: When more than 44 payload bits are clocked, the leading extra bits are discarded and only the last 44 form the word.
- R6: A matching frame with fewer than 44 payload bits produces no strobe and leaves `word_o` unchanged.
- R7: `word_vld_o` goes high at the third rising clock edge after `sel_i` falls and stays high for exactly one cycle.
- R8: A committed word with bit 3, 42 or 43 set raises `tbit_err_o`. The word is still delivered, and the flag stays high until reset.
- R9: `word_o` changes only together with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Frame select: low for address, high for payload, falling edge commits |
| sck_i | input | 1 | Serial bit clock, data taken on its rising edge |
| sdi_i | input | 1 | Serial data |
| word_o | output | 44 | Last committed control word, D0 at bit 0 |
| word_vld_o | output | 1 | One-cycle strobe marking a newly committed word |
| tbit_err_o | output | 1 | Sticky flag: a committed word had a test bit set |

## Verification
A select fall passes two synchroniser flops before the edge detector sees it. The commit register then takes one more edge, so the strobe, the new word and any error flag are all due at the third rising clock edge after `sel_i` is driven low. The bench drives every line on a falling clock edge. After the fall it samples one nanosecond past each of the next six rising edges. It expects the strobe only in the third sample, and nothing at all for frames that must be dropped. The word and the error flag are compared after those six samples, against a model that updates only on frames the bench itself judges valid.

// File: rtl/ctl_rx_pkg.sv
package ctl_rx_pkg;
  localparam int unsigned ADDR_W_DEF   = 8;
  localparam int unsigned WORD_W_DEF   = 44;
  localparam logic [7:0]  DEV_ADDR_DEF = 8'h81;
  localparam logic [43:0] TEST_MASK_DEF =
    (44'd1 << 3) | (44'd1 << 42) | (44'd1 << 43);
  // indices of the lines inside the synchronised bundle
  localparam int unsigned LN_SEL = 0;
  localparam int unsigned LN_SCK = 1;
  localparam int unsigned LN_SDI = 2;
  localparam int unsigned LN_NUM = 3;
endpackage

// File: rtl/ctl_rx_sync.sv
module ctl_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ctl_rx_edge.sv
module ctl_rx_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= cur;
  end
  assign chg = cur ^ prev;
endmodule

// File: rtl/ctl_rx_addr.sv
module ctl_rx_addr #(
  parameter int unsigned   ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h81
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_s,
  input  logic sel_rise,
  input  logic sel_fall,
  input  logic sck_rise,
  input  logic sdi_s,
  output logic match
);
  logic [ADDR_W-1:0] sh;

  // first bit sent ends up in bit 0 after ADDR_W shifts
  always_ff @(posedge clk) begin
    if (rst || sel_fall)       sh <= '0;
    else if (!sel_s && sck_rise) sh <= {sdi_s, sh[ADDR_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst)           match <= 1'b0;
    else if (sel_rise) match <= (sh == DEV_ADDR);
  end
endmodule

// File: rtl/ctl_rx_data.sv
module ctl_rx_data #(
  parameter int unsigned WORD_W = 44,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_s,
  input  logic              sel_rise,
  input  logic              sck_rise,
  input  logic              sdi_s,
  input  logic              match,
  output logic [WORD_W-1:0] data,
  output logic              full
);
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign take = sel_s && sck_rise && match;

  // newest bit enters at the top, so the last WORD_W bits remain
  always_ff @(posedge clk) begin
    if (rst)       data <= '0;
    else if (take) data <= {sdi_s, data[WORD_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst || sel_rise)                      cnt <= '0;
    else if (take && cnt != CNT_W'(WORD_W))   cnt <= cnt + 1'b1;
  end

  assign full = (cnt == CNT_W'(WORD_W));
endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx
  import ctl_rx_pkg::*;
#(
  parameter int unsigned       ADDR_W      = ADDR_W_DEF,
  parameter int unsigned       WORD_W      = WORD_W_DEF,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = DEV_ADDR_DEF,
  parameter logic [WORD_W-1:0] TEST_MASK   = TEST_MASK_DEF,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              tbit_err_o
);
  logic [LN_NUM-1:0] raw, syn;
  logic [1:0]        chg;
  logic              sel_s, sck_s, sdi_s;
  logic              sel_rise, sel_fall, sck_rise;
  logic              match, cnt_full;
  logic [WORD_W-1:0] data;
  logic              commit;

  assign raw[LN_SEL] = sel_i;
  assign raw[LN_SCK] = sck_i;
  assign raw[LN_SDI] = sdi_i;

  ctl_rx_sync #(.W(LN_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign sel_s = syn[LN_SEL];
  assign sck_s = syn[LN_SCK];
  assign sdi_s = syn[LN_SDI];

  ctl_rx_edge #(.W(2)) u_edge (
    .clk(clk), .rst(rst), .cur({sck_s, sel_s}), .chg(chg)
  );

  assign sel_rise = chg[0] &  sel_s;
  assign sel_fall = chg[0] & ~sel_s;
  assign sck_rise = chg[1] &  sck_s;

  ctl_rx_addr #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_addr (
    .clk(clk), .rst(rst), .sel_s(sel_s), .sel_rise(sel_rise),
    .sel_fall(sel_fall), .sck_rise(sck_rise), .sdi_s(sdi_s),
    .match(match)
  );

  ctl_rx_data #(.WORD_W(WORD_W)) u_data (
    .clk(clk), .rst(rst), .sel_s(sel_s), .sel_rise(sel_rise),
    .sck_rise(sck_rise), .sdi_s(sdi_s), .match(match),
    .data(data), .full(cnt_full)
  );

  assign commit = sel_fall && match && cnt_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o     <= '0;
      word_vld_o <= 1'b0;
      tbit_err_o <= 1'b0;
    end else begin
      word_vld_o <= commit;
      if (commit) begin
        word_o <= data;
        if (|(data & TEST_MASK)) tbit_err_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_rx_chk.sv
module ctl_rx_chk #(
  parameter int unsigned WORD_W = 44
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_s,
  input logic              match,
  input logic              cnt_full,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o,
  input logic              tbit_err_o
);
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  a_r7_after_fall: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> !sel_s);

  a_r3_needs_match: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> $past(match));

  a_r6_needs_full: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> $past(cnt_full));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    tbit_err_o |=> tbit_err_o);

  a_r8_err_with_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(tbit_err_o) |-> word_vld_o);

  a_r9_word_hold: assert property (@(posedge clk) disable iff (rst)
    !word_vld_o |-> $stable(word_o));
endmodule

bind ctl_frame_rx ctl_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .sel_s(sel_s), .match(match), .cnt_full(cnt_full),
  .word_o(word_o), .word_vld_o(word_vld_o), .tbit_err_o(tbit_err_o)
);

// File: tb/tb_ctl_frame_rx.sv
`timescale 1ns/1ps
module tb_ctl_frame_rx;
  localparam int HALF = 10;
  localparam int VW   = 74;
  localparam int NV   = 8;
  localparam logic [43:0] TMASK = (44'd1 << 3) | (44'd1 << 42) | (44'd1 << 43);

  // fields: addr value 16, addr bit count 5, pad bits 3, payload bits 6, payload 44
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'h0081, 5'd8,  3'd0, 6'd44, 44'h123_4567_89A0},
    {16'h0081, 5'd8,  3'd4, 6'd44, 44'h2F0_F0F0_F0F0},
    {16'h0080, 5'd8,  3'd0, 6'd44, 44'h0AA_AAAA_AAA0},
    {16'h0001, 5'd8,  3'd0, 6'd44, 44'h155_5555_5550},
    {16'h0081, 5'd8,  3'd0, 6'd43, 44'h0FF_FFFF_FFF0},
    {16'h0817, 5'd12, 3'd0, 6'd44, 44'h0C3_3C3C_3C30},
    {16'h0081, 5'd8,  3'd2, 6'd44, 44'h396_9696_9690},
    {16'h0081, 5'd8,  3'd0, 6'd44, 44'h000_0000_0000}
  };

  logic clk = 1'b0;
  logic rst, sel, sck, sdi;
  logic [43:0] word_o;
  logic word_vld_o, tbit_err_o;

  int checks = 0;
  int errors = 0;
  logic [43:0] m_word = '0;
  logic        m_err  = 1'b0;
  logic [5:0]  vseen;

  always #2.5 clk = ~clk;

  ctl_frame_rx dut (
    .clk(clk), .rst(rst), .sel_i(sel), .sck_i(sck), .sdi_i(sdi),
    .word_o(word_o), .word_vld_o(word_vld_o), .tbit_err_o(tbit_err_o)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk) sdi = b;
    idle(HALF); sck = 1'b1;
    idle(HALF); sck = 1'b0;
    idle(HALF);
  endtask

  // sends a frame, then samples the strobe after each of six edges
  task automatic send(input logic [15:0] a, input int na, input int np,
                      input int nd, input logic [43:0] d);
    @(negedge clk) sel = 1'b0;
    for (int i = 0; i < na; i++) bit_out(a[i]);
    @(negedge clk) sel = 1'b1;
    idle(HALF);
    for (int i = 0; i < np; i++) bit_out(1'b1);
    for (int i = 0; i < nd; i++) bit_out(d[i]);
    @(negedge clk) sel = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      vseen[k] = word_vld_o;
    end
    idle(HALF);
  endtask

  task automatic run_frame(input logic [15:0] a, input int na, input int np,
                           input int nd, input logic [43:0] d);
    logic [7:0] ad;
    logic       ok;
    string      tag;
    ad = 8'((a >> (na - 8)) & 16'h00FF);
    ok = (ad == 8'h81) && (nd >= 44);
    if (ad != 8'h81)   tag = "R3";
    else if (nd < 44)  tag = "R6";
    else if (na > 8)   tag = "R4";
    else if (np > 0)   tag = "R5";
    else               tag = "R2";
    send(a, na, np, nd, d);
    if (ok) begin
      m_word = d;
      if (|(d & TMASK)) m_err = 1'b1;
    end
    // R7: strobe only after the third edge
    check({tag, "/R7 strobe"}, 64'(vseen), ok ? 64'b000100 : 64'b0);
    check({tag, "/R9 word"}, 64'(word_o), 64'(m_word));
    check({tag, "/R8 err"}, 64'(tbit_err_o), 64'(m_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; sel = 1'b0; sck = 1'b0; sdi = 1'b0;
    repeat (5) @(posedge clk); #1;
    check("R1 word in reset", 64'(word_o), 64'd0);
    check("R1 vld in reset", 64'(word_vld_o), 64'd0);
    check("R1 err in reset", 64'(tbit_err_o), 64'd0);
    @(negedge clk) rst = 1'b0;
    idle(4);
    check("R1 idle after reset", 64'({word_o, word_vld_o, tbit_err_o}), 64'd0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][73:58], int'(VEC[v][57:53]), int'(VEC[v][52:50]),
                int'(VEC[v][49:44]), VEC[v][43:0]);
    end

    // R8: test bit 42 set, word still delivered, flag raised
    run_frame(16'h0081, 8, 0, 44, 44'h400_0000_0010);
    check("R8 flag set", 64'(tbit_err_o), 64'd1);
    // R8: clean word afterwards, flag stays
    run_frame(16'h0081, 8, 4, 44, 44'h011_2233_4450);
    check("R8 flag sticky", 64'(tbit_err_o), 64'd1);

    // R1: reset clears everything again
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R1 second reset", 64'({word_o, word_vld_o, tbit_err_o}), 64'd0);
    @(negedge clk) rst = 1'b0;
    m_word = '0; m_err = 1'b0;
    idle(4);

    // R8: bit 3 alone also sets the flag
    run_frame(16'h0081, 8, 0, 44, 44'h000_0000_0008);
    // R8: bit 43 alone, after reset
    @(negedge clk) rst = 1'b1;
    idle(2);
    @(negedge clk) rst = 1'b0;
    m_word = '0; m_err = 1'b0;
    run_frame(16'h0081, 8, 0, 44, 44'h800_0000_0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule